// File: doc/BRIEF.md
# Remappable PIO Address Window

This block places a fixed-size slice of a larger local memory behind a fixed host bus window. Host programmed-I/O accesses that fall inside the window are translated into local addresses. A writable base register picks which window-sized slice of local memory is visible. A read-only size register reports the window size as an address decode mask.

Software writes a base value, and the block cleans it on the way in. Any bits below the window size and any bits at or above the installed memory size are cleared, so only window-aligned bases inside memory are ever stored. On readback, bit 0 of the base register always reads as 1. DMA addresses do not go through the remap: they pass to the local side unchanged.

The register side is a small state machine with three states:
- `RG_IDLE`: no register response this cycle.
- `RG_WRITE`: acknowledge a write.
- `RG_READ`: acknowledge a read and present its data.

The next state is chosen from the request that is present each cycle, from any state:
- `GO_WRITE`: `reg_req` with `reg_we` goes to `RG_WRITE`.
- `GO_READ`: `reg_req` without `reg_we` goes to `RG_READ`.
- `GO_IDLE`: no request goes to `RG_IDLE`.

A base write is committed at the clock edge that accepts the request. An access issued in the following cycle therefore already uses the new base.

Top module: `pio_window_remap`

## Requirements
- R1: After reset, `reg_ack`, `loc_valid`, `loc_miss` and `dma_loc_valid` are 0. The base register reads 0x00000001, and an access at the window start translates to local address 0.
- R2: Bit 0 of a base readback is always 1, whatever was written to bit 0. Writing 0x00200000 reads back 0x00200001.
- R3: On a base write (`reg_sel`=0), the bits below log2 of the window size and the bits at or above log2 of the installed size are stored as 0. Only the bits between them are kept.
- R4: With a 2 MByte window and 64 MByte installed, the readable bases are exactly the 32 values k*0x00200000 | 1 for k = 0..31. Writing 0x04000000 reads back 0x00000001, and writing 0xFFFFFFFF reads back 0x03E00001.
- R5: When the window size equals the installed size, the base always reads 0x00000001, and every in-window access translates to its offset alone.
- R6: The size register (`reg_sel`=1) reads the constant ~(window size - 1), which is 0xFFE00000 for 2 MByte. Writes to it change neither its readback, nor the base readback, nor any translation.
- R7: An access with `acc_addr` inside [WIN_START, WIN_START + window size) raises `loc_valid` for one cycle, in the cycle after `acc_req`. It also drives `loc_addr` = base | (`acc_addr` - WIN_START).
- R8: An access outside the window raises `loc_miss` instead of `loc_valid`, in the cycle after `acc_req`.
- R9: An access issued in the cycle right after a base write request uses the newly written base.
- R10: A DMA address (up to 0x7FFFFF) appears unchanged and zero-extended on `dma_loc_addr`, with `dma_loc_valid`, one cycle after `dma_req`, whatever the base value is.
- R11: Every register request is acknowledged by `reg_ack` exactly one cycle later, and back-to-back requests are accepted. `reg_rdata` is 0 except in the acknowledge cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 1 | 0 = base register, 1 = size register |
| reg_wdata | input | ADDR_W | Register write data |
| reg_ack | output | 1 | Register acknowledge, one cycle after the request |
| reg_rdata | output | ADDR_W | Read data, valid while acknowledging a read |
| acc_req | input | 1 | Host PIO access request |
| acc_addr | input | ADDR_W | Host bus address of the access |
| loc_valid | output | 1 | Translated address valid (hit) |
| loc_miss | output | 1 | Access fell outside the window |
| loc_addr | output | ADDR_W | Translated local address |
| dma_req | input | 1 | DMA address request |
| dma_addr | input | DMA_W | DMA local address |
| dma_loc_valid | output | 1 | DMA address valid |
| dma_loc_addr | output | ADDR_W | DMA local address, passed through |

## Verification
The bench builds two copies that share their inputs:
- `u0` has a 2 MByte window at 0xF7600000 and 64 MByte installed. It brings the full legal base set, over-range and under-aligned write masking, and window-edge hits and misses within reach.
- `u1` has a 64 KByte window at 0xA0000000 and 64 KByte installed. It reaches the degenerate case where no base field exists and every write must leave the base at 0.

Seeded random mixes of writes, reads, accesses and DMA requests run across both copies. Each result is compared against a model of the masked base kept in the bench.

// File: rtl/pio_remap_pkg.sv
package pio_remap_pkg;

    // Register-side controller states
    typedef enum logic [1:0] {
        RG_IDLE  = 2'd0,
        RG_WRITE = 2'd1,
        RG_READ  = 2'd2
    } rg_state_e;

    // Register select encoding
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_RANGE = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/pio_remap_regs.sv
module pio_remap_regs
    import pio_remap_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIN_LG2 = 21,
    parameter int MEM_LG2 = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] base_rb,
    output logic [ADDR_W-1:0] range_rb
);

    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] WIN_MASK  = (ONE << WIN_LG2) - ONE;
    localparam logic [ADDR_W-1:0] MEM_MASK  = (ONE << MEM_LG2) - ONE;
    localparam logic [ADDR_W-1:0] FLD_MASK  = MEM_MASK & ~WIN_MASK;
    localparam logic [ADDR_W-1:0] RANGE_VAL = ~WIN_MASK;

    generate
        if (MEM_LG2 > WIN_LG2) begin : g_remap
            localparam int FLD_W = MEM_LG2 - WIN_LG2;
            logic [FLD_W-1:0] fld_q;
            logic             unused_wd;

            // bits outside the legal field are discarded on write
            assign unused_wd = ^(wdata & ~FLD_MASK);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fld_q <= '0;
                end else if (base_wr_en) begin
                    fld_q <= wdata[MEM_LG2-1:WIN_LG2];
                end
            end

            always_comb begin
                base_q = '0;
                base_q[MEM_LG2-1:WIN_LG2] = fld_q;
            end
        end else begin : g_fixed
            // window spans all of memory: base stays zero
            logic unused_wd;
            assign unused_wd = base_wr_en ^ (^wdata) ^ clk ^ rst_n;
            assign base_q    = '0;
        end
    endgenerate

    assign base_rb  = base_q | ONE;
    assign range_rb = RANGE_VAL;

endmodule

// File: rtl/pio_remap_fsm.sv
module pio_remap_fsm
    import pio_remap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] base_rb,
    input  logic [ADDR_W-1:0] range_rb,
    output logic              base_wr_en,
    output logic              reg_ack,
    output logic [ADDR_W-1:0] reg_rdata
);

    rg_state_e         state_q, state_d;
    logic [ADDR_W-1:0] rd_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_sel);

    // write strobe to the base register, committed at the accepting edge
    assign base_wr_en = reg_req && reg_we && (sel == SEL_BASE);

    // next-state: any state follows the request present this cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_IDLE, RG_WRITE, RG_READ: begin
                if (reg_req && reg_we) begin
                    state_d = RG_WRITE;          // GO_WRITE
                end else if (reg_req) begin
                    state_d = RG_READ;           // GO_READ
                end else begin
                    state_d = RG_IDLE;           // GO_IDLE
                end
            end
            default: state_d = RG_IDLE;
        endcase
    end

    // state register and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RG_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (reg_req && !reg_we) begin
                rd_q <= (sel == SEL_RANGE) ? range_rb : base_rb;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        reg_ack   = 1'b0;
        reg_rdata = '0;
        unique case (state_q)
            RG_IDLE:  ;
            RG_WRITE: reg_ack = 1'b1;
            RG_READ: begin
                reg_ack   = 1'b1;
                reg_rdata = rd_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pio_remap_xlate.sv
module pio_remap_xlate #(
    parameter int                ADDR_W    = 32,
    parameter int                WIN_LG2   = 21,
    parameter int                DMA_W     = 23,
    parameter logic [ADDR_W-1:0] WIN_START = 32'hF760_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              dma_req,
    input  logic [DMA_W-1:0]  dma_addr,
    output logic              loc_valid,
    output logic              loc_miss,
    output logic [ADDR_W-1:0] loc_addr,
    output logic              dma_loc_valid,
    output logic [ADDR_W-1:0] dma_loc_addr
);

    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] WIN_MASK = (ONE << WIN_LG2) - ONE;

    logic              hit;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] loc_d;

    assign hit    = (acc_addr[ADDR_W-1:WIN_LG2] == WIN_START[ADDR_W-1:WIN_LG2]);
    assign offset = acc_addr - WIN_START;
    assign loc_d  = base_q | (offset & WIN_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_valid     <= 1'b0;
            loc_miss      <= 1'b0;
            loc_addr      <= '0;
            dma_loc_valid <= 1'b0;
            dma_loc_addr  <= '0;
        end else begin
            loc_valid     <= acc_req && hit;
            loc_miss      <= acc_req && !hit;
            if (acc_req && hit) begin
                loc_addr <= loc_d;
            end
            dma_loc_valid <= dma_req;
            if (dma_req) begin
                dma_loc_addr <= ADDR_W'(dma_addr);
            end
        end
    end

endmodule

// File: rtl/pio_window_remap.sv
module pio_window_remap #(
    parameter int                ADDR_W    = 32,
    parameter int                WIN_LG2   = 21,
    parameter int                MEM_LG2   = 26,
    parameter int                DMA_W     = 23,
    parameter logic [ADDR_W-1:0] WIN_START = 32'hF760_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              reg_ack,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              loc_valid,
    output logic              loc_miss,
    output logic [ADDR_W-1:0] loc_addr,
    input  logic              dma_req,
    input  logic [DMA_W-1:0]  dma_addr,
    output logic              dma_loc_valid,
    output logic [ADDR_W-1:0] dma_loc_addr
);

    logic              base_wr_en;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] base_rb;
    logic [ADDR_W-1:0] range_rb;

    pio_remap_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .base_rb    (base_rb),
        .range_rb   (range_rb),
        .base_wr_en (base_wr_en),
        .reg_ack    (reg_ack),
        .reg_rdata  (reg_rdata)
    );

    pio_remap_regs #(
        .ADDR_W  (ADDR_W),
        .WIN_LG2 (WIN_LG2),
        .MEM_LG2 (MEM_LG2)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr_en (base_wr_en),
        .wdata      (reg_wdata),
        .base_q     (base_q),
        .base_rb    (base_rb),
        .range_rb   (range_rb)
    );

    pio_remap_xlate #(
        .ADDR_W    (ADDR_W),
        .WIN_LG2   (WIN_LG2),
        .DMA_W     (DMA_W),
        .WIN_START (WIN_START)
    ) u_xlate (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_req       (acc_req),
        .acc_addr      (acc_addr),
        .base_q        (base_q),
        .dma_req       (dma_req),
        .dma_addr      (dma_addr),
        .loc_valid     (loc_valid),
        .loc_miss      (loc_miss),
        .loc_addr      (loc_addr),
        .dma_loc_valid (dma_loc_valid),
        .dma_loc_addr  (dma_loc_addr)
    );

endmodule

// File: rtl/pio_window_remap_chk.sv
module pio_window_remap_chk #(
    parameter int                ADDR_W    = 32,
    parameter int                WIN_LG2   = 21,
    parameter int                MEM_LG2   = 26,
    parameter int                DMA_W     = 23,
    parameter logic [ADDR_W-1:0] WIN_START = 32'hF760_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic              reg_sel,
    input logic              reg_ack,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              acc_req,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              loc_valid,
    input logic              loc_miss,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              dma_req,
    input logic [DMA_W-1:0]  dma_addr,
    input logic              dma_loc_valid,
    input logic [ADDR_W-1:0] dma_loc_addr
);

    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] WIN_MASK = (ONE << WIN_LG2) - ONE;
    localparam logic [ADDR_W-1:0] MEM_MASK = (ONE << MEM_LG2) - ONE;
    localparam logic [ADDR_W-1:0] KEEP     = (MEM_MASK & ~WIN_MASK) | ONE;

    logic in_win;
    assign in_win = (acc_addr[ADDR_W-1:WIN_LG2] == WIN_START[ADDR_W-1:WIN_LG2]);

    // R2
    base_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && !reg_sel) |=> (reg_ack && reg_rdata[0]));

    // R3
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && !reg_sel) |=> ((reg_rdata & ~KEEP) == '0));

    // R6
    range_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && reg_sel) |=> (reg_rdata == ~WIN_MASK));

    // R7
    hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && in_win) |=> (loc_valid && !loc_miss
            && ((loc_addr & WIN_MASK) == ($past(acc_addr) & WIN_MASK))
            && ((loc_addr & ~MEM_MASK) == '0)));

    // R8
    miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !in_win) |=> (loc_miss && !loc_valid));

    // R10
    dma_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> (dma_loc_valid && dma_loc_addr == ADDR_W'($past(dma_addr))));

    // R11
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> reg_ack);

    // R11
    no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |=> (!reg_ack && reg_rdata == '0));

endmodule

bind pio_window_remap pio_window_remap_chk #(
    .ADDR_W    (ADDR_W),
    .WIN_LG2   (WIN_LG2),
    .MEM_LG2   (MEM_LG2),
    .DMA_W     (DMA_W),
    .WIN_START (WIN_START)
) u_chk (.*);

// File: tb/sim_pio_window_remap.sv
module sim_pio_window_remap;

    localparam logic [31:0] WIN0 = 32'hF760_0000;
    localparam logic [31:0] WIN1 = 32'hA000_0000;
    localparam logic [31:0] FM0  = 32'h03E0_0000;
    localparam logic [31:0] OM0  = 32'h001F_FFFF;
    localparam logic [31:0] OM1  = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        acc_req = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        dma_req = 1'b0;
    logic [22:0] dma_addr = '0;

    logic        ack0, ack1, lv0, lv1, lm0, lm1, dv0, dv1;
    logic [31:0] rd0, rd1, la0, la1, da0, da1;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_base = '0;

    always #2 clk = ~clk;

    pio_window_remap u0 (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_ack(ack0), .reg_rdata(rd0),
        .acc_req(acc_req), .acc_addr(acc_addr), .loc_valid(lv0), .loc_miss(lm0),
        .loc_addr(la0), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_loc_valid(dv0), .dma_loc_addr(da0)
    );

    pio_window_remap #(.WIN_LG2(16), .MEM_LG2(16), .WIN_START(WIN1)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_ack(ack1), .reg_rdata(rd1),
        .acc_req(acc_req), .acc_addr(acc_addr), .loc_valid(lv1), .loc_miss(lm1),
        .loc_addr(la1), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_loc_valid(dv1), .dma_loc_addr(da1)
    );

    function automatic logic [31:0] masked0(input logic [31:0] d);
        return d & FM0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic do_write(input logic sel, input logic [31:0] d, input string tag);
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
        chk({tag, " R11 ack0"}, 32'(ack0), 32'd1);
        chk({tag, " R11 ack1"}, 32'(ack1), 32'd1);
        if (!sel) exp_base = masked0(d);
    endtask

    task automatic do_read(input logic sel, input string tag);
        reg_req = 1'b1; reg_we = 1'b0; reg_sel = sel;
        @(negedge clk);
        reg_req = 1'b0;
        if (sel) begin
            chk({tag, " R6 range0"}, rd0, 32'hFFE0_0000);
            chk({tag, " R6 range1"}, rd1, 32'hFFFF_0000);
        end else begin
            chk({tag, " R2 R3 base0"}, rd0, exp_base | 32'd1);
            chk({tag, " R5 base1"}, rd1, 32'd1);
        end
    endtask

    task automatic do_acc(input logic [31:0] a, input string tag);
        logic h0, h1;
        acc_req = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_req = 1'b0;
        h0 = (a[31:21] == WIN0[31:21]);
        h1 = (a[31:16] == WIN1[31:16]);
        chk({tag, " R7 R8 valid0"}, {30'd0, lm0, lv0}, {30'd0, !h0, h0});
        chk({tag, " R7 R8 valid1"}, {30'd0, lm1, lv1}, {30'd0, !h1, h1});
        if (h0) chk({tag, " R7 addr0"}, la0, exp_base | (a & OM0));
        if (h1) chk({tag, " R5 addr1"}, la1, a & OM1);
    endtask

    task automatic do_dma(input logic [22:0] a, input string tag);
        dma_req = 1'b1; dma_addr = a;
        @(negedge clk);
        dma_req = 1'b0;
        chk({tag, " R10 dma0"}, {dv0, da0[30:0]}, {1'b1, 8'd0, a});
        chk({tag, " R10 dma1"}, {dv1, da1[30:0]}, {1'b1, 8'd0, a});
        chk({tag, " R10 dma hi"}, {31'd0, da0[31] | da1[31]}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idle outputs", {28'd0, ack0, lv0, lm0, dv0}, 32'd0);
        do_read(1'b0, "R1 reset base");
        do_acc(WIN0, "R1 window start");
        do_acc(WIN1 + 32'h1234, "R5 offset only");

        // R2 bit 0 hardwired
        do_write(1'b0, 32'h0020_0000, "R2 w");
        do_read(1'b0, "R2 r");
        do_write(1'b0, 32'h0040_0001, "R2 w1");
        do_read(1'b0, "R2 r1");
        chk("R2 literal", rd0, 32'h0040_0001);

        // R3 / R4 masking and legal set
        do_write(1'b0, 32'h03E0_0000, "R4 top");
        do_read(1'b0, "R4 top");
        chk("R4 top literal", rd0, 32'h03E0_0001);
        do_write(1'b0, 32'h0400_0000, "R4 over");
        do_read(1'b0, "R4 over");
        chk("R4 over literal", rd0, 32'h0000_0001);
        do_write(1'b0, 32'hFFFF_FFFF, "R3 ones");
        do_read(1'b0, "R3 ones");
        chk("R3 ones literal", rd0, 32'h03E0_0001);
        for (int k = 0; k < 32; k++) begin
            do_write(1'b0, 32'(k) << 21 | 32'h0001_2345, "R4 legal");
            do_read(1'b0, "R4 legal");
            do_acc(WIN0 + 32'h0000_0100, "R4 legal acc");
        end

        // R6 range writes ignored
        do_write(1'b0, 32'h0120_0000, "R6 base");
        do_write(1'b1, 32'h1234_5678, "R6 rw");
        do_read(1'b1, "R6 after");
        do_read(1'b0, "R6 base kept");
        do_acc(WIN0 + 32'h1F_FFFC, "R6 xlate kept");

        // R8 window edges
        do_acc(WIN0 - 32'd4, "R8 below");
        do_acc(WIN0 + 32'h0020_0000, "R8 above");
        do_acc(WIN1 + 32'h0001_0000, "R8 above1");

        // R9 back-to-back write then access
        do_write(1'b0, 32'h02A0_0000, "R9 w");
        do_acc(WIN0 + 32'h0000_0040, "R9 next");
        do_write(1'b0, 32'h0000_0000, "R9 w2");
        do_acc(WIN0 + 32'h0000_0040, "R9 next2");

        // R10 DMA unaffected by remap
        do_write(1'b0, 32'h01E0_0000, "R10 base");
        do_dma(23'h7F_FFFF, "R10 max");
        do_dma(23'h00_0000, "R10 zero");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            unique case (r[2:0])
                3'd0, 3'd1: do_write(r[3], $urandom, "rnd write");
                3'd2:       do_read(r[3], "rnd read");
                3'd3:       do_dma(23'($urandom), "rnd dma");
                3'd4:       do_acc($urandom, "rnd far");
                3'd5:       do_acc(WIN1 | ($urandom & OM1), "rnd win1");
                default:    do_acc(WIN0 | ($urandom & OM0), "rnd win0");
            endcase
        end

        @(negedge clk);
        summary();
        $finish;
    end

endmodule